// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is the datapath of a simple processor in which every register shares one internal bus. It holds eight general-purpose registers, a scratch register Y that feeds the ALU's first operand, and a result register Z that captures the ALU output. Each cycle, an external sequencer supplies the control signals. These are per-register load and drive strobes, the operand select, the ALU operation code, and the Y and Z enables. Each such control word moves one value across the bus and can, in the same cycle, compute one ALU result.

The ALU is purely combinational. Its first operand is either Y or the constant 4, and its second operand is whatever is on the bus. A result survives only if it is captured in Z, and it reaches a general register only when Z later drives the bus. A data inlet lets the surrounding logic place a word on the bus, standing in for the memory side. All register contents, the bus value and a contention flag are visible at the ports.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, all general registers, Y and Z read zero. With no drive strobe active, the bus reads zero and the contention flag is 0.
- R2: A general register whose load strobe is 1 takes the bus value at the rising clock edge. Several registers may load the same value in one edge. A register whose load strobe is 0 keeps its value.
- R3: A general register whose drive strobe is 1 places its contents on the bus in the same cycle, and the value appears on `bus_value`.
- R4: When no source drives the bus, `bus_value` is zero.
- R5: `bus_conflict` is 1 in any cycle where more than one of the bus sources is active, and 0 otherwise. The sources are the general-register drive strobes, `z_drive` and `ext_drive`. The bus value in a conflict cycle is undefined.
- R6: The ALU's first operand is Y when `opa_sel_y` is 1 and the constant 4 when it is 0. The second operand is the bus value.
- R7: `alu_op` selects the ALU function as follows. 3'b000 adds A+B modulo 2^32. 3'b001 subtracts A−B modulo 2^32. 3'b010 gives A AND B. 3'b011 gives A OR B. 3'b100 passes B. Every other code gives zero.
- R8: Z takes the ALU result at the clock edge only when `z_load` is 1, and otherwise holds. Y takes the bus value only when `y_load` is 1, and otherwise holds.
- R9: The sequence (R1 drive, Y load), then (R2 drive, select Y, add, Z load), then (Z drive, R3 load) leaves R1+R2 in R3 after three cycles.
- R10: When `ext_drive` is 1, `ext_data` is the bus source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gpr_load | input | 8 | Per-register load strobes, bit k for register k |
| gpr_drive | input | 8 | Per-register bus drive strobes, bit k for register k |
| y_load | input | 1 | Load Y from the bus |
| z_load | input | 1 | Load Z from the ALU result |
| z_drive | input | 1 | Z drives the bus |
| ext_drive | input | 1 | Data inlet drives the bus |
| ext_data | input | 32 | Data placed on the bus by the inlet |
| opa_sel_y | input | 1 | First-operand select: 1 = Y, 0 = constant 4 |
| alu_op | input | 3 | ALU function code |
| regs_flat | output | 256 | Register k occupies bits [32k+31:32k] |
| y_value | output | 32 | Contents of Y |
| z_value | output | 32 | Contents of Z |
| bus_value | output | 32 | Current bus value |
| bus_conflict | output | 1 | More than one bus source active |

## Verification
A vector table drives three-step transfers. Each step loads Y from the inlet, presents the second operand on the bus while Z captures the ALU output, and then moves Z into a rotating destination register. The vectors cover every defined code and one undefined code, so a swapped or dropped function shows up. Operand pairs are picked to tell the functions apart: unequal patterns separate AND from OR, and a subtraction whose result goes negative exposes operand order. An add that wraps exposes truncation errors, and selecting the constant 4 exposes a stuck operand multiplexer. Directed tests then cover the classic three-cycle register add, hold behaviour without strobes, the zero idle bus, single-driver versus multi-driver contention, and a reset in the middle of a run.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ALU_ADD  = 3'b000,
    ALU_SUB  = 3'b001,
    ALU_AND  = 3'b010,
    ALU_OR   = 3'b011,
    ALU_PASS = 3'b100
  } alu_op_e;
endpackage

// File: rtl/sbus_bus.sv
module sbus_bus #(
  parameter int DATA_W = 32,
  parameter int NSRC   = 10
) (
  input  logic [NSRC-1:0][DATA_W-1:0] src_data,
  input  logic [NSRC-1:0]             src_en,
  output logic [DATA_W-1:0]           value,
  output logic                        conflict
);
  localparam int CNT_W = $clog2(NSRC + 1);

  logic [CNT_W-1:0] active_cnt;

  always_comb begin
    value      = '0;
    active_cnt = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_en[s]) begin
        value      = value | src_data[s];
        active_cnt = active_cnt + CNT_W'(1);
      end
    end
    conflict = (active_cnt > CNT_W'(1));
  end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] y_q,
  input  logic              sel_y,
  input  logic [DATA_W-1:0] opb,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] CONST_FOUR = DATA_W'(4);

  logic [DATA_W-1:0] opa;

  always_comb begin
    opa = sel_y ? y_q : CONST_FOUR;
    case (alu_op_e'(op))
      ALU_ADD:  result = opa + opb;
      ALU_SUB:  result = opa - opb;
      ALU_AND:  result = opa & opb;
      ALU_OR:   result = opa | opb;
      ALU_PASS: result = opb;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREGS-1:0]             load,
  input  logic [DATA_W-1:0]            bus,
  output logic [NREGS-1:0][DATA_W-1:0] q
);
  logic [NREGS-1:0][DATA_W-1:0] d;

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    always_comb begin
      d[k] = load[k] ? bus : q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[k] <= '0;
      else        q[k] <= d[k];
    end
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREGS-1:0]          gpr_load,
  input  logic [NREGS-1:0]          gpr_drive,
  input  logic                      y_load,
  input  logic                      z_load,
  input  logic                      z_drive,
  input  logic                      ext_drive,
  input  logic [DATA_W-1:0]         ext_data,
  input  logic                      opa_sel_y,
  input  logic [2:0]                alu_op,
  output logic [NREGS*DATA_W-1:0]   regs_flat,
  output logic [DATA_W-1:0]         y_value,
  output logic [DATA_W-1:0]         z_value,
  output logic [DATA_W-1:0]         bus_value,
  output logic                      bus_conflict
);
  localparam int NSRC = NREGS + 2;

  logic [1:0]                   rst_sync;
  logic                         rst_n_int;
  logic [NREGS-1:0][DATA_W-1:0] gpr_q;
  logic [NSRC-1:0][DATA_W-1:0]  src_data;
  logic [NSRC-1:0]              src_en;
  logic [DATA_W-1:0]            bus;
  logic [DATA_W-1:0]            alu_res;
  logic [DATA_W-1:0]            y_q, y_d;
  logic [DATA_W-1:0]            z_q, z_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  always_comb begin
    for (int k = 0; k < NREGS; k++) begin
      src_data[k] = gpr_q[k];
      src_en[k]   = gpr_drive[k];
    end
    src_data[NREGS]   = z_q;
    src_en[NREGS]     = z_drive;
    src_data[NREGS+1] = ext_data;
    src_en[NREGS+1]   = ext_drive;
  end

  sbus_bus #(.DATA_W(DATA_W), .NSRC(NSRC)) u_bus (
    .src_data (src_data),
    .src_en   (src_en),
    .value    (bus),
    .conflict (bus_conflict)
  );

  sbus_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (gpr_load),
    .bus   (bus),
    .q     (gpr_q)
  );

  sbus_alu #(.DATA_W(DATA_W)) u_alu (
    .y_q    (y_q),
    .sel_y  (opa_sel_y),
    .opb    (bus),
    .op     (alu_op),
    .result (alu_res)
  );

  always_comb begin
    y_d = y_load ? bus : y_q;
    z_d = z_load ? alu_res : z_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      y_q <= '0;
      z_q <= '0;
    end else begin
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  assign regs_flat = gpr_q;
  assign y_value   = y_q;
  assign z_value   = z_q;
  assign bus_value = bus;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 8
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic [NREGS-1:0]        gpr_load,
  input logic [NREGS-1:0]        gpr_drive,
  input logic                    y_load,
  input logic                    z_load,
  input logic                    z_drive,
  input logic                    ext_drive,
  input logic [NREGS*DATA_W-1:0] regs_flat,
  input logic [DATA_W-1:0]       y_value,
  input logic [DATA_W-1:0]       z_value,
  input logic [DATA_W-1:0]       bus_value,
  input logic                    bus_conflict
);
  logic [NREGS+1:0] drivers;
  assign drivers = {ext_drive, z_drive, gpr_drive};

  // R5
  multi_drive_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($countones(drivers) > 1) |-> bus_conflict);

  // R5
  single_drive_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($countones(drivers) <= 1) |-> !bus_conflict);

  // R4
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (drivers == '0) |-> (bus_value == '0));

  // R3
  z_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (z_drive && $countones(drivers) == 1) |-> (bus_value == z_value));

  // R8
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !z_load |=> $stable(z_value));

  // R8
  y_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    y_load |=> (y_value == $past(bus_value)));

  for (genvar k = 0; k < NREGS; k++) begin : g_gpr
    // R2
    gpr_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      gpr_load[k] |=> (regs_flat[k*DATA_W +: DATA_W] == $past(bus_value)));
    // R2
    gpr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      !gpr_load[k] |=> $stable(regs_flat[k*DATA_W +: DATA_W]));
  end
endmodule

bind sbus_datapath sbus_datapath_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_n_int),
  .gpr_load     (gpr_load),
  .gpr_drive    (gpr_drive),
  .y_load       (y_load),
  .z_load       (z_load),
  .z_drive      (z_drive),
  .ext_drive    (ext_drive),
  .regs_flat    (regs_flat),
  .y_value      (y_value),
  .z_value      (z_value),
  .bus_value    (bus_value),
  .bus_conflict (bus_conflict)
);

// File: tb/sbus_datapath_test.sv
`timescale 1ns/1ps
module sbus_datapath_test;
  localparam int W = 32;
  localparam int N = 8;
  localparam int NV = 10;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   gpr_load, gpr_drive;
  logic           y_load, z_load, z_drive, ext_drive, opa_sel_y;
  logic [W-1:0]   ext_data;
  logic [2:0]     alu_op;
  logic [N*W-1:0] regs_flat;
  logic [W-1:0]   y_value, z_value, bus_value;
  logic           bus_conflict;

  int checks = 0;
  int errors = 0;

  sbus_datapath uut (
    .clk(clk), .rst_n(rst_n), .gpr_load(gpr_load), .gpr_drive(gpr_drive),
    .y_load(y_load), .z_load(z_load), .z_drive(z_drive), .ext_drive(ext_drive),
    .ext_data(ext_data), .opa_sel_y(opa_sel_y), .alu_op(alu_op),
    .regs_flat(regs_flat), .y_value(y_value), .z_value(z_value),
    .bus_value(bus_value), .bus_conflict(bus_conflict)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {op[2:0], sel_y, y, b, expected}
  localparam logic [99:0] VEC [NV] = '{
    {3'b000, 1'b1, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {3'b001, 1'b1, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007},
    {3'b001, 1'b1, 32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9},
    {3'b010, 1'b1, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
    {3'b011, 1'b1, 32'h0F0F_0000, 32'h0000_00F0, 32'h0F0F_00F0},
    {3'b100, 1'b1, 32'h0000_1234, 32'hCAFE_BABE, 32'hCAFE_BABE},
    {3'b000, 1'b0, 32'h0000_0064, 32'h0000_0008, 32'h0000_000C},
    {3'b000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001},
    {3'b001, 1'b0, 32'h0000_0055, 32'h0000_0001, 32'h0000_0003},
    {3'b101, 1'b1, 32'h1111_1111, 32'h2222_2222, 32'h0000_0000}
  };

  function automatic logic [W-1:0] reg_at(input int k);
    return regs_flat[k*W +: W];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    gpr_load = '0; gpr_drive = '0; y_load = 0; z_load = 0; z_drive = 0;
    ext_drive = 0; ext_data = '0; opa_sel_y = 1; alu_op = 3'b000;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    quiet();
    repeat (2) tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic load_ext(input int k, input logic [W-1:0] v);
    quiet(); ext_drive = 1; ext_data = v; gpr_load[k] = 1;
    tick(); quiet();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    for (int k = 0; k < N; k++) check("R1 gpr reset", reg_at(k), '0);
    check("R1 y reset", y_value, '0);
    check("R1 z reset", z_value, '0);
    check("R1 idle bus", bus_value, '0);
    check("R1 flag", {31'b0, bus_conflict}, '0);

    // R6 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      int dst;
      dst = i % N;
      quiet(); ext_drive = 1; ext_data = VEC[i][95:64]; y_load = 1;
      tick();
      quiet(); ext_drive = 1; ext_data = VEC[i][63:32];
      opa_sel_y = VEC[i][96]; alu_op = VEC[i][99:97]; z_load = 1;
      tick();
      check("R7 z result", z_value, VEC[i][31:0]);
      quiet(); z_drive = 1; gpr_load[dst] = 1;
      tick();
      quiet();
      check("R6 R7 gpr from z", reg_at(dst), VEC[i][31:0]);
    end

    // R9: three-cycle add R3 = R1 + R2
    load_ext(1, 32'h0000_1000);
    load_ext(2, 32'h0000_0234);
    gpr_drive[1] = 1; y_load = 1; tick(); quiet();
    gpr_drive[2] = 1; opa_sel_y = 1; alu_op = 3'b000; z_load = 1; tick(); quiet();
    z_drive = 1; gpr_load[3] = 1; tick(); quiet();
    check("R9 r3 sum", reg_at(3), 32'h0000_1234);
    check("R9 r1 kept", reg_at(1), 32'h0000_1000);

    // R3 R10: single sources on the bus, no conflict
    gpr_drive[2] = 1; #1;
    check("R3 gpr drives bus", bus_value, 32'h0000_0234);
    check("R5 single source no flag", {31'b0, bus_conflict}, '0);
    quiet(); ext_drive = 1; ext_data = 32'hA5A5_0001; #1;
    check("R10 inlet on bus", bus_value, 32'hA5A5_0001);
    quiet(); #1;
    check("R4 idle bus zero", bus_value, '0);

    // R5: contention
    gpr_drive[1] = 1; gpr_drive[2] = 1; #1;
    check("R5 two gprs flag", {31'b0, bus_conflict}, 32'd1);
    quiet(); z_drive = 1; ext_drive = 1; #1;
    check("R5 z plus inlet flag", {31'b0, bus_conflict}, 32'd1);
    quiet(); tick();

    // R8: Z and Y hold without enables
    ext_drive = 1; ext_data = 32'h0000_7777; alu_op = 3'b100; tick(); quiet();
    check("R8 z holds", z_value, 32'h0000_1234);
    check("R8 y holds", y_value, 32'h0000_1000);

    // R2: multiple loads in one edge, others hold
    ext_drive = 1; ext_data = 32'hBEEF_0042; gpr_load[5] = 1; gpr_load[6] = 1;
    tick(); quiet();
    check("R2 r5 loaded", reg_at(5), 32'hBEEF_0042);
    check("R2 r6 loaded", reg_at(6), 32'hBEEF_0042);
    check("R2 r3 held", reg_at(3), 32'h0000_1234);

    // R1: reset in mid-run
    do_reset();
    check("R1 r5 cleared", reg_at(5), '0);
    check("R1 z cleared", z_value, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule